// File: doc/BRIEF.md
# Serial EEPROM transaction controller

This block turns a single request into the complete sequence of byte-level bus operations needed to read a block from, or write a block to, a device on a two-wire serial bus. It sits above a byte engine that performs one START-plus-byte, one plain byte write, one byte read or one STOP at a time, and reports back whether the byte was acknowledged. The controller decides what to send, waits for each answer, reacts to refusals, and streams the data in or out.

Two addressing styles exist. In normal mode the device address is sent first, then a one-byte register offset. Reads then reach the data phase through a repeated START, with no STOP and after a bus-free pause. In legacy mode the device takes the address byte itself as the offset, shifted up by one with the direction in bit 0. Reads run for any length, with the device auto-incrementing. Writes are cut into chunks of at most `CHUNK` bytes. Each chunk is addressed on its own, closed with STOP, and then followed by acknowledge polling until the device has finished its internal write cycle.

Data streams are valid/ready. Write data is consumed only while `wd_ready` is high, and a byte is taken in the cycle where `wd_valid` and `wd_ready` are both high. The controller holds a read byte on `rd_data` with `rd_valid` high until `rd_ready` is seen, and it does not fetch the next byte from the bus until then, so back-pressure stalls the bus and loses no data. Byte-engine commands follow the same rule: a command is held until `cmd_ready`, and its response (`rsp_valid` pulse) must come at least one cycle after acceptance.

Top module: `eeprom_xact_ctrl`

## Requirements
- R1: In legacy mode the transfer opens with a START byte equal to {offset[6:0], dir}, where dir is 1 for read and 0 for write, and no separate offset byte is ever sent.
- R2: A normal-mode read sends START with {dev, 0}, then the offset byte, then waits at least `BUF_CYC` cycles without a STOP, then sends START with {dev, 1}, so the whole read uses exactly one STOP.
- R3: If an address or offset byte is not acknowledged, the controller sends STOP and then ends with `done` and `err` both high.
- R4: A read of N bytes issues N byte reads, with ACK on the first N-1 and NACK on the last, then STOP. Data leaves on the read stream in rising address order and stays stable while `rd_valid` is high and `rd_ready` is low.
- R5: A write of N bytes is split into ceil(N/CHUNK) chunks. Each chunk starts with its own addressing phase at the offset advanced by the bytes already written, and each chunk ends with STOP.
- R6: After each write chunk the controller sends START with {dev, 1} up to `POLL_MAX` times, with a STOP after every refused attempt. If all attempts are refused, the transfer ends with an error.
- R7: When a poll is acknowledged, one byte is read with NACK and then STOP follows. That byte never appears on the read stream.
- R8: A refused write-data byte ends the transfer with STOP, `done` and `err`.
- R9: Between the response to any STOP and the acceptance of the next START there are at least `BUF_CYC` cycles.
- R10: A request of length 0 completes with `done` high and `err` low, and no byte-engine command is issued.
- R11: `req_ready` is high only while idle. At most one engine command is outstanding, and a presented command is held unchanged until accepted.
- R12: `done` is a one-cycle pulse per request, and `err` is only ever high together with `done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle if valid |
| req_write | input | 1 | 1 = write transfer, 0 = read transfer |
| req_legacy | input | 1 | 1 = address byte carries the offset |
| req_dev | input | 7 | Device address (normal mode and polling) |
| req_offset | input | 8 | Starting register offset |
| req_len | input | LEN_W | Number of data bytes |
| wd_valid | input | 1 | Write data byte present |
| wd_ready | output | 1 | Controller takes a write byte |
| wd_data | input | 8 | Write data byte |
| rd_valid | output | 1 | Read data byte present |
| rd_ready | input | 1 | Consumer takes the read byte |
| rd_data | output | 8 | Read data byte |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with failure (only with done) |
| cmd_valid | output | 1 | Engine command present |
| cmd_ready | input | 1 | Engine accepts the command |
| cmd_op | output | 2 | 0 = write byte, 1 = read byte, 2 = STOP |
| cmd_start | output | 1 | With op 0: precede the byte with START |
| cmd_nack | output | 1 | With op 1: answer the byte with NACK |
| cmd_byte | output | 8 | Byte to write |
| rsp_valid | input | 1 | Engine response pulse |
| rsp_nack | input | 1 | Written byte was not acknowledged |
| rsp_byte | input | 8 | Byte received by a read |

## Verification
The hardest situation to reach from the ports is a device that stays busy across several polling attempts, including the case where it stays busy for exactly the last permitted attempt or one beyond it. The bench's byte-engine model holds a device with a programmable busy count that is reloaded after every committed chunk. Busy counts of 0, 1, `POLL_MAX`-1 and `POLL_MAX` drive the polling loop to success on the first, second and last attempt, and then to exhaustion. Data refusals are injected at a chosen write-byte index so that the failure lands mid-chunk, after a full chunk has already been polled. The model also timestamps STOP and offset responses so that every START can be checked against the bus-free gap.

// File: rtl/xc_pkg.sv
package xc_pkg;

  // Byte-engine command encoding
  typedef enum logic [1:0] {
    OP_WRITE = 2'd0,
    OP_READ  = 2'd1,
    OP_STOP  = 2'd2
  } xc_op_e;

  typedef enum logic [3:0] {
    S_IDLE,
    S_HEAD,    // START + first address byte
    S_OFS,     // register offset byte (normal mode)
    S_RADR,    // repeated START + read address (normal read)
    S_RD,      // fetch one data byte
    S_RDOUT,   // present byte on read stream
    S_WFETCH,  // take one byte from write stream
    S_WD,      // send write data byte
    S_POLL,    // completion poll START
    S_DRAIN,   // read and discard after poll acknowledged
    S_STOP,    // STOP condition
    S_BUFW,    // bus-free wait
    S_FIN      // completion pulse
  } xc_state_e;

endpackage

// File: rtl/xc_buf_timer.sv
module xc_buf_timer #(
  parameter int BUF_CYC = 12000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int W = (BUF_CYC > 1) ? $clog2(BUF_CYC + 1) : 1;

  logic [W-1:0] cnt_q;

  assign expired = (cnt_q == W'(BUF_CYC - 1));

  always_ff @(posedge clk) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run)       cnt_q <= '0;
    else if (!expired)   cnt_q <= cnt_q + 1'b1;
  end
endmodule

// File: rtl/xc_xfer_count.sv
module xc_xfer_count #(
  parameter int LEN_W = 8,
  parameter int CHUNK = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [LEN_W-1:0] len_in,
  input  logic [7:0]       ofs_in,
  input  logic             step,
  output logic             rem_last,
  output logic             rem_zero,
  output logic             chunk_end,
  output logic [7:0]       ofs
);
  logic [LEN_W-1:0] rem_q;
  logic [7:0]       ofs_q;
  logic             at_edge;

  assign rem_last  = (rem_q == LEN_W'(1));
  assign rem_zero  = (rem_q == '0);
  assign chunk_end = at_edge || rem_last;
  assign ofs       = ofs_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rem_q <= '0;
      ofs_q <= '0;
    end else if (load) begin
      rem_q <= len_in;
      ofs_q <= ofs_in;
    end else if (step) begin
      rem_q <= rem_q - 1'b1;
      ofs_q <= ofs_q + 8'd1;
    end
  end

  generate
    if (CHUNK > 1) begin : g_multi
      localparam int CW = $clog2(CHUNK);
      logic [CW-1:0] pos_q;
      assign at_edge = (pos_q == CW'(CHUNK - 1));
      always_ff @(posedge clk) begin
        if (!rst_n || load)  pos_q <= '0;
        else if (step)       pos_q <= chunk_end ? '0 : pos_q + 1'b1;
      end
    end else begin : g_single
      assign at_edge = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/xc_poll_budget.sv
module xc_poll_budget #(
  parameter int POLL_MAX = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic load,
  input  logic dec,
  output logic last
);
  localparam int PW = $clog2(POLL_MAX + 1);

  logic [PW-1:0] left_q;

  assign last = (left_q <= PW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n)     left_q <= '0;
    else if (load)  left_q <= PW'(POLL_MAX);
    else if (dec && left_q != '0) left_q <= left_q - 1'b1;
  end
endmodule

// File: rtl/eeprom_xact_ctrl.sv
module eeprom_xact_ctrl
  import xc_pkg::*;
#(
  parameter int LEN_W    = 8,
  parameter int CHUNK    = 4,
  parameter int POLL_MAX = 8,
  parameter int BUF_CYC  = 12000
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic             req_legacy,
  input  logic [6:0]       req_dev,
  input  logic [7:0]       req_offset,
  input  logic [LEN_W-1:0] req_len,
  input  logic             wd_valid,
  output logic             wd_ready,
  input  logic [7:0]       wd_data,
  output logic             rd_valid,
  input  logic             rd_ready,
  output logic [7:0]       rd_data,
  output logic             done,
  output logic             err,
  output logic             cmd_valid,
  input  logic             cmd_ready,
  output logic [1:0]       cmd_op,
  output logic             cmd_start,
  output logic             cmd_nack,
  output logic [7:0]       cmd_byte,
  input  logic             rsp_valid,
  input  logic             rsp_nack,
  input  logic [7:0]       rsp_byte
);
  xc_state_e st_q, after_q;
  logic      pend_q, fail_q;
  logic      wr_q, leg_q;
  logic [6:0] dev_q;
  logic [7:0] rbuf_q, wbuf_q;

  logic rem_last, rem_zero, chunk_end, poll_last, buf_done;
  logic [7:0] ofs;
  logic issue_st, got, got_ack, got_nack, accept, step;
  xc_op_e op_c;

  assign issue_st = (st_q == S_HEAD) || (st_q == S_OFS) || (st_q == S_RADR) ||
                    (st_q == S_RD)   || (st_q == S_WD)  || (st_q == S_POLL) ||
                    (st_q == S_DRAIN) || (st_q == S_STOP);
  assign cmd_valid = issue_st && !pend_q;
  assign got       = rsp_valid && pend_q;
  assign got_ack   = got && !rsp_nack;
  assign got_nack  = got && rsp_nack;
  assign accept    = (st_q == S_IDLE) && req_valid;
  assign step      = ((st_q == S_WD) && got_ack) || ((st_q == S_RDOUT) && rd_ready);

  assign req_ready = (st_q == S_IDLE);
  assign wd_ready  = (st_q == S_WFETCH);
  assign rd_valid  = (st_q == S_RDOUT);
  assign rd_data   = rbuf_q;
  assign done      = (st_q == S_FIN);
  assign err       = done && fail_q;
  assign cmd_op    = op_c;

  // Command fields per state
  always_comb begin
    op_c      = OP_WRITE;
    cmd_start = 1'b0;
    cmd_nack  = 1'b0;
    cmd_byte  = 8'h00;
    case (st_q)
      S_HEAD: begin
        cmd_start = 1'b1;
        cmd_byte  = leg_q ? {ofs[6:0], ~wr_q} : {dev_q, 1'b0};
      end
      S_OFS:   cmd_byte = ofs;
      S_RADR, S_POLL: begin
        cmd_start = 1'b1;
        cmd_byte  = {dev_q, 1'b1};
      end
      S_RD: begin
        op_c     = OP_READ;
        cmd_nack = rem_last;
      end
      S_DRAIN: begin
        op_c     = OP_READ;
        cmd_nack = 1'b1;
      end
      S_WD:    cmd_byte = wbuf_q;
      S_STOP:  op_c = OP_STOP;
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= S_IDLE;
      after_q <= S_IDLE;
      pend_q  <= 1'b0;
      fail_q  <= 1'b0;
      wr_q    <= 1'b0;
      leg_q   <= 1'b0;
      dev_q   <= '0;
      rbuf_q  <= '0;
      wbuf_q  <= '0;
    end else begin
      if (cmd_valid && cmd_ready) pend_q <= 1'b1;
      else if (rsp_valid)         pend_q <= 1'b0;

      case (st_q)
        S_IDLE: if (accept) begin
          wr_q   <= req_write;
          leg_q  <= req_legacy;
          dev_q  <= req_dev;
          fail_q <= 1'b0;
          st_q   <= (req_len == '0) ? S_FIN : S_HEAD;
        end
        S_HEAD: if (got_nack) begin
          fail_q <= 1'b1; after_q <= S_FIN; st_q <= S_STOP;
        end else if (got_ack) begin
          if (!leg_q)     st_q <= S_OFS;
          else if (wr_q)  st_q <= S_WFETCH;
          else            st_q <= S_RD;
        end
        S_OFS: if (got_nack) begin
          fail_q <= 1'b1; after_q <= S_FIN; st_q <= S_STOP;
        end else if (got_ack) begin
          if (wr_q) st_q <= S_WFETCH;
          else begin
            after_q <= S_RADR; st_q <= S_BUFW;
          end
        end
        S_RADR: if (got_nack) begin
          fail_q <= 1'b1; after_q <= S_FIN; st_q <= S_STOP;
        end else if (got_ack) st_q <= S_RD;
        S_RD: if (got) begin
          rbuf_q <= rsp_byte;
          st_q   <= S_RDOUT;
        end
        S_RDOUT: if (rd_ready) begin
          if (rem_last) begin
            after_q <= S_FIN; st_q <= S_STOP;
          end else st_q <= S_RD;
        end
        S_WFETCH: if (wd_valid) begin
          wbuf_q <= wd_data;
          st_q   <= S_WD;
        end
        S_WD: if (got_nack) begin
          fail_q <= 1'b1; after_q <= S_FIN; st_q <= S_STOP;
        end else if (got_ack) begin
          if (chunk_end) begin
            after_q <= S_POLL; st_q <= S_STOP;
          end else st_q <= S_WFETCH;
        end
        S_POLL: if (got_ack) st_q <= S_DRAIN;
        else if (got_nack) begin
          if (poll_last) begin
            fail_q <= 1'b1; after_q <= S_FIN;
          end else after_q <= S_POLL;
          st_q <= S_STOP;
        end
        S_DRAIN: if (got) begin
          after_q <= rem_zero ? S_FIN : S_HEAD;
          st_q    <= S_STOP;
        end
        S_STOP:  if (got) st_q <= S_BUFW;
        S_BUFW:  if (buf_done) st_q <= after_q;
        S_FIN:   st_q <= S_IDLE;
        default: st_q <= S_IDLE;
      endcase
    end
  end

  xc_xfer_count #(.LEN_W(LEN_W), .CHUNK(CHUNK)) u_count (
    .clk       (clk),
    .rst_n     (rst_n),
    .load      (accept),
    .len_in    (req_len),
    .ofs_in    (req_offset),
    .step      (step),
    .rem_last  (rem_last),
    .rem_zero  (rem_zero),
    .chunk_end (chunk_end),
    .ofs       (ofs)
  );

  xc_poll_budget #(.POLL_MAX(POLL_MAX)) u_poll (
    .clk   (clk),
    .rst_n (rst_n),
    .load  ((st_q == S_WD) && got_ack && chunk_end),
    .dec   ((st_q == S_POLL) && got_nack),
    .last  (poll_last)
  );

  xc_buf_timer #(.BUF_CYC(BUF_CYC)) u_buf (
    .clk     (clk),
    .rst_n   (rst_n),
    .run     (st_q == S_BUFW),
    .expired (buf_done)
  );
endmodule

// File: rtl/xc_checker.sv
module xc_checker #(
  parameter int LEN_W   = 8,
  parameter int BUF_CYC = 12000
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             req_ready,
  input logic [LEN_W-1:0] req_len,
  input logic             wd_ready,
  input logic             rd_valid,
  input logic             rd_ready,
  input logic [7:0]       rd_data,
  input logic             done,
  input logic             err,
  input logic             cmd_valid,
  input logic             cmd_ready,
  input logic [1:0]       cmd_op,
  input logic             cmd_start,
  input logic [7:0]       cmd_byte,
  input logic             rsp_valid
);
  localparam int GW = $clog2(BUF_CYC + 1);

  logic          outst_q, seen_q;
  logic [1:0]    last_op_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      outst_q   <= 1'b0;
      seen_q    <= 1'b0;
      last_op_q <= 2'd0;
      gap_q     <= GW'(BUF_CYC);
    end else begin
      if (cmd_valid && cmd_ready) begin
        outst_q   <= 1'b1;
        seen_q    <= 1'b1;
        last_op_q <= cmd_op;
      end else if (rsp_valid) outst_q <= 1'b0;
      if (req_valid && req_ready) seen_q <= 1'b0;
      if (rsp_valid && outst_q && last_op_q == 2'd2) gap_q <= '0;
      else if (gap_q < GW'(BUF_CYC)) gap_q <= gap_q + 1'b1;
    end
  end

  AST_CMD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && !cmd_ready |=> cmd_valid && $stable(cmd_op) && $stable(cmd_byte)); // R11
  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    outst_q |-> !cmd_valid); // R11
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !cmd_valid && !rd_valid && !wd_ready); // R11
  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready |=> rd_valid && $stable(rd_data)); // R4
  AST_BUS_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready && cmd_op == 2'd0 && cmd_start |-> gap_q >= GW'(BUF_CYC)); // R9
  AST_END_ON_STOP: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !seen_q || last_op_q == 2'd2); // R3
  AST_ZERO_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid && req_ready && req_len == '0 |=> done && !err); // R10
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R12
endmodule

bind eeprom_xact_ctrl xc_checker #(.LEN_W(LEN_W), .BUF_CYC(BUF_CYC)) u_xc_checker (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_valid (req_valid),
  .req_ready (req_ready),
  .req_len   (req_len),
  .wd_ready  (wd_ready),
  .rd_valid  (rd_valid),
  .rd_ready  (rd_ready),
  .rd_data   (rd_data),
  .done      (done),
  .err       (err),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .cmd_op    (cmd_op),
  .cmd_start (cmd_start),
  .cmd_byte  (cmd_byte),
  .rsp_valid (rsp_valid)
);

// File: tb/eeprom_xact_ctrl_bench.sv
`timescale 1ns/1ps
module eeprom_xact_ctrl_bench;
  localparam int LEN_W = 8, CHUNK = 4, PMAX = 4, BUF = 6;
  localparam logic [6:0] DEV = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req_valid = 0, req_write = 0, req_legacy = 0;
  logic [6:0] req_dev = DEV;
  logic [7:0] req_offset = 0;
  logic [LEN_W-1:0] req_len = 0;
  logic wd_valid = 0, rd_ready = 0, cmd_ready = 0;
  logic [7:0] wd_data;
  logic req_ready, wd_ready, rd_valid, done, err, cmd_valid, cmd_start, cmd_nack;
  logic [7:0] rd_data, cmd_byte;
  logic [1:0] cmd_op;
  logic rsp_valid = 0, rsp_nack = 0;
  logic [7:0] rsp_byte = 0;

  always #2.5 clk = ~clk;

  eeprom_xact_ctrl #(.LEN_W(LEN_W), .CHUNK(CHUNK), .POLL_MAX(PMAX), .BUF_CYC(BUF))
  u_eeprom_xact_ctrl (.*);

  int checks = 0, errors = 0, cyc = 0, pat = 0;
  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // stimulus patterns for handshakes, changed away from the clock edge
  always @(negedge clk) begin
    pat <= pat + 1;
    cmd_ready <= (pat % 4) != 1;
    rd_ready  <= (pat % 3) != 0;
    wd_valid  <= (pat % 5) != 2;
  end
  always @(posedge clk) cyc <= cyc + 1;

  // write source and read sink
  logic [7:0] wsrc [16];
  logic [7:0] rbuf [16];
  int wn = 0, rn = 0;
  assign wd_data = wsrc[wn % 16];
  always @(posedge clk) begin
    if (wd_valid && wd_ready) wn <= wn + 1;
    if (rd_valid && rd_ready) begin rbuf[rn % 16] <= rd_data; rn <= rn + 1; end
  end

  // byte-engine plus device model
  logic [7:0] mem [256];
  logic [7:0] refm [256];
  logic m_leg = 0;
  int busy = 0, busy_k = 0, nack_at = -1, phase = 0, ptr = 0, pc = 0, ndata = 0;
  int n_cmds, n_starts, n_stops, n_ofs, n_ard, n_nrd, n_gapbad, head_byte;
  int t_stop = -1000, t_ofs = -1000;
  bit rep_pend = 0;
  logic [7:0] pa [16];
  logic [7:0] pd [16];

  always @(posedge clk) begin
    rsp_valid <= 1'b0;
    if (rst_n && cmd_valid && cmd_ready) begin
      rsp_valid <= 1'b1; rsp_nack <= 1'b0; rsp_byte <= 8'h00;
      n_cmds++;
      if (cmd_op == 2'd0 && cmd_start) begin
        n_starts++;
        if (cyc - t_stop < BUF) n_gapbad++;
        if (rep_pend && cyc - t_ofs < BUF) n_gapbad++;
        rep_pend = 0;
        if (n_starts == 1) head_byte = cmd_byte;
        if (busy > 0) begin rsp_nack <= 1'b1; busy--; phase = 0; end
        else if (m_leg) begin ptr = cmd_byte[7:1]; phase = cmd_byte[0] ? 3 : 2; end
        else if (cmd_byte[7:1] != DEV) begin rsp_nack <= 1'b1; phase = 0; end
        else phase = cmd_byte[0] ? 3 : 1;
      end else if (cmd_op == 2'd0) begin
        if (phase == 1) begin
          ptr = cmd_byte; phase = 2; n_ofs++; rep_pend = 1; t_ofs = cyc + 1;
        end else if (phase == 2) begin
          rep_pend = 0;
          if (ndata == nack_at) rsp_nack <= 1'b1;
          else begin pa[pc % 16] = 8'(ptr); pd[pc % 16] = cmd_byte; pc++; ptr = (ptr + 1) % 256; end
          ndata++;
        end else rsp_nack <= 1'b1;
      end else if (cmd_op == 2'd1) begin
        rsp_byte <= mem[ptr];
        ptr = (ptr + 1) % 256;
        if (cmd_nack) n_nrd++; else n_ard++;
      end else begin
        n_stops++; t_stop = cyc + 1; rep_pend = 0; phase = 0;
        if (pc > 0) begin
          for (int i = 0; i < pc; i++) mem[pa[i]] = pd[i];
          busy = busy_k;
        end
        pc = 0;
      end
    end
  end

  bit got_err;
  task automatic run(input bit w, input bit leg, input int ofs, input int len,
                     input int k, input int nat, input bit bad);
    int t;
    @(negedge clk);
    n_cmds = 0; n_starts = 0; n_stops = 0; n_ofs = 0; n_ard = 0; n_nrd = 0;
    n_gapbad = 0; head_byte = -1; ndata = 0; pc = 0; busy = 0;
    busy_k = k; nack_at = nat; m_leg = leg; wn = 0; rn = 0;
    for (int i = 0; i < 16; i++) wsrc[i] = 8'((ofs * 3 + i * 11 + len + 1) & 255);
    req_write = w; req_legacy = leg; req_offset = 8'(ofs); req_len = LEN_W'(len);
    req_dev = bad ? DEV + 7'd1 : DEV; req_valid = 1'b1;
    do @(posedge clk); while (!req_ready);
    @(negedge clk); req_valid = 1'b0;
    t = 0;
    while (!done && t < 20000) begin @(negedge clk); t++; end
    chk(done == 1'b1, "R12 done reached", int'(done), 1);
    got_err = err;
    @(negedge clk);
    chk(done == 1'b0, "R12 done single pulse", int'(done), 0);
  endtask

  task automatic check_mem(input string tag);
    int bad = 0;
    for (int i = 0; i < 256; i++) if (mem[i] !== refm[i]) bad++;
    chk(bad == 0, tag, bad, 0);
  endtask

  task automatic do_write(input bit leg, input int ofs, input int len, input int k);
    int c = (len + CHUNK - 1) / CHUNK;
    run(1, leg, ofs, len, k, -1, 0);
    for (int i = 0; i < len; i++) refm[(ofs + i) % 256] = wsrc[i];
    chk(got_err == 0, "R5 write no error", int'(got_err), 0);
    chk(n_starts == c * (k + 2), "R6 poll start count", n_starts, c * (k + 2));
    chk(n_stops == c * (k + 2), "R5 stop per chunk and poll", n_stops, c * (k + 2));
    chk(n_nrd == c && n_ard == 0, "R7 one nacked drain read per chunk", n_nrd, c);
    chk(rn == 0, "R7 drained byte not streamed", rn, 0);
    chk(n_ofs == (leg ? 0 : c), "R1 offset bytes per chunk", n_ofs, leg ? 0 : c);
    chk(n_gapbad == 0, "R9 bus-free gap", n_gapbad, 0);
    if (leg) chk(head_byte == {ofs[6:0], 1'b0}, "R1 legacy write head", head_byte, {ofs[6:0], 1'b0});
    check_mem("R5 memory after chunked write");
  endtask

  task automatic do_read(input bit leg, input int ofs, input int len);
    int bad = 0;
    run(0, leg, ofs, len, 0, -1, 0);
    chk(got_err == 0, "R4 read no error", int'(got_err), 0);
    chk(rn == len, "R4 byte count on stream", rn, len);
    for (int i = 0; i < len && i < 16; i++) if (rbuf[i] !== refm[(ofs + i) % 256]) bad++;
    chk(bad == 0, "R4 data in address order", bad, 0);
    chk(n_ard == len - 1 && n_nrd == 1, "R4 ack all but last", n_ard, len - 1);
    chk(n_stops == 1, "R2 single stop, repeated start", n_stops, 1);
    chk(n_starts == (leg ? 1 : 2), "R2 start count", n_starts, leg ? 1 : 2);
    chk(n_gapbad == 0, "R2 bus-free before repeated start", n_gapbad, 0);
    if (leg) chk(head_byte == {ofs[6:0], 1'b1}, "R1 legacy read head", head_byte, {ofs[6:0], 1'b1});
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    chk(0, "watchdog expired", 0, 1);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    for (int i = 0; i < 256; i++) begin mem[i] = 8'((i * 7 + 3) & 255); refm[i] = mem[i]; end
    repeat (4) @(negedge clk);
    chk(req_ready == 1 && cmd_valid == 0 && done == 0, "R11 reset state", int'(req_ready), 1);
    rst_n = 1'b1;
    @(negedge clk);

    for (int len = 1; len <= 9; len++) do_write(0, 8'h20 + len * 16, len, len % 2);
    for (int len = 1; len <= 9; len++) do_read(0, 8'h20 + len * 16, len);
    for (int len = 1; len <= 6; len++) do_write(1, 10 * len, len, 0);
    for (int len = 1; len <= 6; len++) do_read(1, 10 * len, len);
    do_write(0, 8'h05, 2, PMAX - 1);                         // R6 last poll succeeds

    run(1, 0, 8'h08, 2, PMAX, -1, 0);                        // R6 exhaustion
    chk(got_err == 1, "R6 poll exhaustion error", int'(got_err), 1);
    chk(n_starts == 1 + PMAX && n_stops == 1 + PMAX, "R6 attempts bounded", n_starts, 1 + PMAX);
    chk(n_nrd == 0, "R6 no drain after exhaustion", n_nrd, 0);
    for (int i = 0; i < 256; i++) refm[i] = mem[i];

    run(0, 0, 8'h10, 3, 0, -1, 1);                           // R3 address refused
    chk(got_err == 1 && n_stops == 1 && n_starts == 1, "R3 read address nack", n_stops, 1);
    run(1, 0, 8'h10, 3, 0, -1, 1);
    chk(got_err == 1 && n_stops == 1 && n_ofs == 0, "R3 write address nack", n_stops, 1);

    run(1, 0, 8'h60, 9, 0, 5, 0);                            // R8 data refused mid-chunk
    chk(got_err == 1, "R8 data nack error", int'(got_err), 1);
    chk(n_stops == 3 && n_nrd == 1, "R8 stop after data nack", n_stops, 3);
    for (int i = 0; i < 256; i++) refm[i] = mem[i];

    run(0, 0, 8'h00, 0, 0, -1, 0);                           // R10
    chk(got_err == 0 && n_cmds == 0, "R10 zero length quiet", n_cmds, 0);
    run(1, 1, 8'h00, 0, 0, -1, 0);
    chk(got_err == 0 && n_cmds == 0, "R10 zero length write", n_cmds, 0);

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule